// File: doc/BRIEF.md
# I2C Target Register Access Engine

This block is a bus-target-only I2C front end. It gives an external controller read and write access to a byte-wide register space that sits next to it on the chip. The SCL and SDA pad inputs are oversampled on the system clock. The block reaches the bus only through an open-drain enable: when `sda_oe` is high, the pad pulls SDA low. The block never creates START, STOP or SCL edges, and it never stretches the clock.

A write frame has three parts. The 7-bit device address comes first, with the direction bit clear. Two pointer bytes follow, high byte first. Every byte after that is written to the register file at the pointer. A read frame returns the byte at the pointer and keeps going until the controller answers with a NACK. An internal control bit at register `0x00FD` selects whether the pointer steps after each byte. When it steps, it stays inside its 256-byte page.

The upper device-address bits can come from a configuration input. They can also come from package pins, either followed live or captured once after reset. The lower bits always come from configuration.

Top module: `i2c_regport`

## Requirements
- R1: After reset, `sda_oe` and `reg_we` are low, `reg_addr` is 0x0000, and the control bit reads back as 0, so auto-increment is enabled.
- R2: A START is SDA falling while SCL is high. It is accepted at any point in a frame, including as a repeated START, and it restarts reception of the address byte. A STOP is SDA rising while SCL is high. It releases SDA and returns the engine to idle.
- R3: The device address is {upper bits, `cfg_addr_lo`}, 7 bits in all. It is compared against bits 7..1 of the first byte, which is shifted in MSB first. Bit 0 of that byte is the direction: 0 for write, 1 for read. On a match the target pulls SDA low during the ninth clock. On a mismatch it does not acknowledge, and it ignores the bus until the next START.
- R4: When `addr_from_pins`=1 and `addr_pin_latch`=0, the upper address bits follow `pin_addr_hi` live. When `addr_from_pins`=0, they come from `cfg_addr_hi`.
- R5: When `addr_from_pins`=1 and `addr_pin_latch`=1, `pin_addr_hi` is captured on the first clock after reset. Later pin changes do not alter the address.
- R6: In a write frame, the two bytes after the address set the pointer, high byte first. Each later byte produces one single-cycle `reg_we` pulse with `reg_addr` equal to the pointer. Every received byte is acknowledged.
- R7: In a read frame, the byte at the pointer is shifted out MSB first. `sda_oe` changes only after a detected SCL falling edge, START or STOP.
- R8: When the control bit is 0, the pointer advances by one after each byte written or transmitted. When it is 1, the pointer holds.
- R9: A pointer step increments only the low 8 bits, so 0xFF wraps to 0x00, and the high byte is kept.
- R10: A NACK from the controller after a transmitted byte makes the target release SDA. It drives nothing more until the next START.
- R11: A write to pointer 0x00FD sets the control bit from data bit 0 and is also passed to the register file. A read at 0x00FD returns the control bit in bit 0, with zeros in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe | output | 1 | High pulls SDA low |
| pin_addr_hi | input | HI_W | Upper device-address bits from pins |
| cfg_addr_hi | input | HI_W | Upper device-address bits from configuration |
| cfg_addr_lo | input | 7-HI_W | Lower device-address bits |
| addr_from_pins | input | 1 | Take the upper bits from the pins |
| addr_pin_latch | input | 1 | Capture the pins once after reset |
| reg_addr | output | 16 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe, one cycle |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |

## Verification
Some properties hold on every cycle, and the assertions check those. The write strobe is a single-cycle pulse that follows an SCL falling edge. The SDA enable changes only after a falling edge, START or STOP. A START or STOP always releases the line. A pointer step after a write never leaves the page. Other behaviours can only be shown by whole frames from the bench's scenarios. These are: address matching from each upper-bit source, pointer loading, burst data landing at consecutive addresses, the page wrap, the auto-increment control, repeated START, and the silence after a NACK.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 16;
    localparam int DEV_W  = 7;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } eng_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_PTR_HI,
        PH_PTR_LO,
        PH_DATA
    } rx_ph_e;

    typedef struct packed {
        eng_st_e           st;
        rx_ph_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] ptr_hi;
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  waddr;
        logic [BYTE_W-1:0] wdata;
        logic              ctl;
        logic              oe;
        logic              we;
        logic              to_tx;
        logic              acked;
    } eng_s;

    function automatic logic [PTR_W-1:0] page_step(input logic [PTR_W-1:0] p);
        page_step = {p[PTR_W-1:BYTE_W], p[BYTE_W-1:0] + 8'd1};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_lvl
);

    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_prev;
        logic              sda_prev;
    } line_s;

    line_s q, d;
    logic [STAGES-1:0] scl_shift, sda_shift;

    generate
        if (STAGES == 1) begin : g_single
            assign scl_shift = scl_i;
            assign sda_shift = sda_i;
        end else begin : g_chain
            assign scl_shift = {q.scl[STAGES-2:0], scl_i};
            assign sda_shift = {q.sda[STAGES-2:0], sda_i};
        end
    endgenerate

    logic scl_now, sda_now;
    assign scl_now = q.scl[STAGES-1];
    assign sda_now = q.sda[STAGES-1];

    always_comb begin
        d          = q;
        d.scl      = scl_shift;
        d.sda      = sda_shift;
        d.scl_prev = scl_now;
        d.sda_prev = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_rise  = scl_now & ~q.scl_prev;
    assign scl_fall  = ~scl_now & q.scl_prev;
    assign start_det = scl_now & q.scl_prev & q.sda_prev & ~sda_now;
    assign stop_det  = scl_now & q.scl_prev & ~q.sda_prev & sda_now;
    assign sda_lvl   = sda_now;

endmodule

// File: rtl/i2c_addr_src.sv
module i2c_addr_src #(
    parameter int HI_W = 4,
    parameter int LO_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HI_W-1:0]      pin_hi,
    input  logic [HI_W-1:0]      cfg_hi,
    input  logic [LO_W-1:0]      cfg_lo,
    input  logic                 use_pins,
    input  logic                 latch_pins,
    output logic [HI_W+LO_W-1:0] dev_addr
);

    typedef struct packed {
        logic [HI_W-1:0] cap;
        logic            done;
    } cap_s;

    cap_s q, d;
    logic [HI_W-1:0] hi_sel;

    always_comb begin
        d = q;
        if (!q.done) begin
            d.cap  = pin_hi;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (!use_pins) begin
            hi_sel = cfg_hi;
        end else if (latch_pins) begin
            hi_sel = q.cap;
        end else begin
            hi_sel = pin_hi;
        end
    end

    assign dev_addr = {hi_sel, cfg_lo};

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [PTR_W-1:0] CTL_ADDR = 16'h00FD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_lvl,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_s q, d;
    logic [BYTE_W-1:0] tx_src;

    assign tx_src = (q.ptr == CTL_ADDR) ? {{(BYTE_W-1){1'b0}}, q.ctl} : reg_rdata;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (start_det) begin
            d.st  = ST_RX;
            d.ph  = PH_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        d.oe  = 1'b1;
                        d.st  = ST_RX_ACK;
                        case (q.ph)
                            PH_DEV: begin
                                if (q.sh[BYTE_W-1:1] == dev_addr) begin
                                    d.to_tx = q.sh[0];
                                    d.ph    = PH_PTR_HI;
                                end else begin
                                    d.oe = 1'b0;
                                    d.st = ST_IDLE;
                                end
                            end
                            PH_PTR_HI: begin
                                d.ptr_hi = q.sh;
                                d.ph     = PH_PTR_LO;
                            end
                            PH_PTR_LO: begin
                                d.ptr = {q.ptr_hi, q.sh};
                                d.ph  = PH_DATA;
                            end
                            PH_DATA: begin
                                d.we    = 1'b1;
                                d.waddr = q.ptr;
                                d.wdata = q.sh;
                                if (q.ptr == CTL_ADDR) begin
                                    d.ctl = q.sh[0];
                                end
                                if (!q.ctl) begin
                                    d.ptr = page_step(q.ptr);
                                end
                            end
                            default: d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.to_tx) begin
                            d.sh = tx_src;
                            d.oe = ~tx_src[BYTE_W-1];
                            d.st = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt != '0) begin
                        if (q.cnt < LAST_BIT) begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_TX_ACK;
                            if (!q.ctl) begin
                                d.ptr = page_step(q.ptr);
                            end
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.acked = ~sda_lvl;
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.acked) begin
                            d.sh = tx_src;
                            d.oe = ~tx_src[BYTE_W-1];
                            d.st = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.oe;
    assign reg_we    = q.we;
    assign reg_wdata = q.wdata;
    assign reg_addr  = q.we ? q.waddr : q.ptr;

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_tgt_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               HI_W        = 4,
    parameter logic [PTR_W-1:0] CTL_ADDR    = 16'h00FD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [HI_W-1:0]   pin_addr_hi,
    input  logic [HI_W-1:0]   cfg_addr_hi,
    input  logic [6-HI_W:0]   cfg_addr_lo,
    input  logic              addr_from_pins,
    input  logic              addr_pin_latch,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam int LO_W = DEV_W - HI_W;

    logic scl_rise_w, scl_fall_w, start_w, stop_w, sda_lvl_w;
    logic [DEV_W-1:0] dev_addr_w;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .sda_lvl   (sda_lvl_w)
    );

    i2c_addr_src #(.HI_W(HI_W), .LO_W(LO_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_hi     (pin_addr_hi),
        .cfg_hi     (cfg_addr_hi),
        .cfg_lo     (cfg_addr_lo),
        .use_pins   (addr_from_pins),
        .latch_pins (addr_pin_latch),
        .dev_addr   (dev_addr_w)
    );

    i2c_tgt_engine #(.CTL_ADDR(CTL_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .sda_lvl   (sda_lvl_w),
        .dev_addr  (dev_addr_w),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we)
    );

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        reg_we,
    input logic [15:0] reg_addr,
    input logic        scl_fall,
    input logic        start_det,
    input logic        stop_det
);

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R6

    AST_WE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(scl_fall)); // R6

    AST_OE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R7

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R2

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R2

    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr[15:8] == $past(reg_addr[15:8]))); // R9

endmodule

bind i2c_regport i2c_regport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .scl_fall  (scl_fall_w),
    .start_det (start_w),
    .stop_det  (stop_w)
);

// File: tb/i2c_regport_bench.sv
`timescale 1ns/1ps
module i2c_regport_bench;

    localparam int Q = 10;
    localparam logic [3:0] CFG_HI = 4'b1001;
    localparam logic [2:0] CFG_LO = 3'b011;
    localparam logic [7:0] DEV_W8 = {CFG_HI, CFG_LO, 1'b0};
    localparam logic [7:0] DEV_R8 = {CFG_HI, CFG_LO, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_c = 1'b1;
    logic sda_c = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [3:0] pin_hi = 4'b0000;
    logic from_pins = 1'b0;
    logic pin_latch = 1'b0;
    logic [15:0] reg_addr;
    logic [7:0] reg_wdata;
    logic reg_we;
    logic [7:0] reg_rdata;
    logic [7:0] mem [0:511];

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    assign sda_line  = sda_c & ~sda_oe;
    assign reg_rdata = mem[reg_addr[8:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr[8:0]] <= reg_wdata;
        end
    end

    i2c_regport u_i2c_regport (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_c),
        .sda_i          (sda_line),
        .sda_oe         (sda_oe),
        .pin_addr_hi    (pin_hi),
        .cfg_addr_hi    (CFG_HI),
        .cfg_addr_lo    (CFG_LO),
        .addr_from_pins (from_pins),
        .addr_pin_latch (pin_latch),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_we         (reg_we),
        .reg_rdata      (reg_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        scl_c = 1'b1;
        sda_c = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_c = 1'b1; scl_c = 1'b1; wq();
        sda_c = 1'b0; wq();
        scl_c = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_c = 1'b1; wq();
        scl_c = 1'b1; wq();
        sda_c = 1'b0; wq();
        scl_c = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_c = 1'b0; wq();
        scl_c = 1'b1; wq();
        sda_c = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_c = b[i]; wq();
            scl_c = 1'b1; wq(); wq();
            scl_c = 1'b0; wq();
        end
        sda_c = 1'b1; wq();
        scl_c = 1'b1; wq();
        ack = !sda_line; wq();
        scl_c = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_c = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wq();
            scl_c = 1'b1; wq();
            b = {b[6:0], sda_line}; wq();
            scl_c = 1'b0;
        end
        wq();
        sda_c = give_ack ? 1'b0 : 1'b1; wq();
        scl_c = 1'b1; wq(); wq();
        scl_c = 1'b0; wq();
        sda_c = 1'b1;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        bit a;
        bus_start();
        send_byte(DEV_W8, a);
        check(a, "R3 address ack", a, 1);
        send_byte(p[15:8], a);
        check(a, "R6 pointer high ack", a, 1);
        send_byte(p[7:0], a);
        check(a, "R6 pointer low ack", a, 1);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        bit a;
        check(sda_oe == 1'b0, "R1 sda_oe at reset", sda_oe, 0);
        check(reg_we == 1'b0, "R1 reg_we at reset", reg_we, 0);
        check(reg_addr == 16'h0000, "R1 reg_addr at reset", reg_addr, 0);
        set_ptr(16'h00FD);
        bus_rstart();
        send_byte(DEV_R8, a);
        recv_byte(1'b0, b);
        bus_stop();
        check(b == 8'h00, "R1 control bit after reset", b, 0);
    endtask

    task automatic t_write_burst();
        bit a;
        set_ptr(16'h0120);
        send_byte(8'hA1, a); check(a, "R6 data ack 0", a, 1);
        send_byte(8'hB2, a); check(a, "R6 data ack 1", a, 1);
        send_byte(8'hC3, a); check(a, "R6 data ack 2", a, 1);
        bus_stop();
        check(mem[9'h120] == 8'hA1, "R6 write 0x120", mem[9'h120], 8'hA1);
        check(mem[9'h121] == 8'hB2, "R8 write 0x121", mem[9'h121], 8'hB2);
        check(mem[9'h122] == 8'hC3, "R8 write 0x122", mem[9'h122], 8'hC3);
    endtask

    task automatic t_read_back();
        logic [7:0] b;
        bit a;
        bit drove;
        set_ptr(16'h0120);
        bus_stop();
        bus_start();
        send_byte(DEV_R8, a);
        check(a, "R3 read address ack", a, 1);
        recv_byte(1'b1, b); check(b == 8'hA1, "R7 read byte 0", b, 8'hA1);
        recv_byte(1'b1, b); check(b == 8'hB2, "R8 read byte 1", b, 8'hB2);
        recv_byte(1'b0, b); check(b == 8'hC3, "R8 read byte 2", b, 8'hC3);
        drove = 1'b0;
        for (int i = 0; i < 9; i++) begin
            wq();
            scl_c = 1'b1; wq();
            if (sda_oe) drove = 1'b1;
            wq();
            scl_c = 1'b0; wq();
        end
        check(!drove, "R10 silent after NACK", drove, 0);
        bus_stop();
    endtask

    task automatic t_rstart();
        logic [7:0] b;
        bit a;
        set_ptr(16'h0121);
        bus_rstart();
        send_byte(DEV_R8, a);
        check(a, "R2 ack after repeated START", a, 1);
        recv_byte(1'b0, b);
        bus_stop();
        check(b == 8'hB2, "R2 read after repeated START", b, 8'hB2);
    endtask

    task automatic t_wrap();
        bit a;
        set_ptr(16'h01FE);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
        check(mem[9'h1FE] == 8'h11, "R9 write 0x1FE", mem[9'h1FE], 8'h11);
        check(mem[9'h1FF] == 8'h22, "R9 write 0x1FF", mem[9'h1FF], 8'h22);
        check(mem[9'h100] == 8'h33, "R9 wrap to 0x100", mem[9'h100], 8'h33);
    endtask

    task automatic t_noinc();
        logic [7:0] b;
        bit a;
        set_ptr(16'h00FD);
        send_byte(8'h01, a);
        check(a, "R11 control write ack", a, 1);
        bus_stop();
        set_ptr(16'h00FD);
        bus_rstart();
        send_byte(DEV_R8, a);
        recv_byte(1'b0, b);
        bus_stop();
        check(b == 8'h01, "R11 control read back", b, 8'h01);
        set_ptr(16'h0130);
        send_byte(8'h55, a);
        send_byte(8'h66, a);
        bus_stop();
        check(mem[9'h130] == 8'h66, "R8 hold pointer write", mem[9'h130], 8'h66);
        check(mem[9'h131] == 8'h00, "R8 no step on write", mem[9'h131], 0);
        set_ptr(16'h0130);
        bus_rstart();
        send_byte(DEV_R8, a);
        recv_byte(1'b1, b); check(b == 8'h66, "R8 hold read 0", b, 8'h66);
        recv_byte(1'b0, b); check(b == 8'h66, "R8 hold read 1", b, 8'h66);
        bus_stop();
        set_ptr(16'h00FD);
        send_byte(8'h00, a);
        bus_stop();
        set_ptr(16'h0130);
        bus_rstart();
        send_byte(DEV_R8, a);
        recv_byte(1'b1, b); check(b == 8'h66, "R8 step read 0", b, 8'h66);
        recv_byte(1'b0, b); check(b == 8'h00, "R8 step read 1", b, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit a;
        bus_start();
        send_byte({CFG_HI, CFG_LO ^ 3'b001, 1'b0}, a);
        check(!a, "R3 mismatch not acked", a, 0);
        send_byte(8'h01, a);
        check(!a, "R3 ignored byte not acked", a, 0);
        send_byte(8'h40, a);
        send_byte(8'h99, a);
        bus_stop();
        check(mem[9'h140] == 8'h00, "R3 no write after mismatch", mem[9'h140], 0);
    endtask

    task automatic t_pins();
        bit a;
        from_pins = 1'b1;
        pin_latch = 1'b0;
        pin_hi = 4'b0110;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte({4'b0110, CFG_LO, 1'b0}, a);
        bus_stop();
        check(a, "R4 pin address acked", a, 1);
        bus_start();
        send_byte(DEV_W8, a);
        bus_stop();
        check(!a, "R4 config address refused", a, 0);
        pin_hi = CFG_HI;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte(DEV_W8, a);
        bus_stop();
        check(a, "R4 live pin change", a, 1);
        from_pins = 1'b0;
        pin_hi = 4'b0110;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte(DEV_W8, a);
        bus_stop();
        check(a, "R4 config source", a, 1);
    endtask

    task automatic t_latch();
        bit a;
        from_pins = 1'b1;
        pin_latch = 1'b1;
        pin_hi = 4'b0101;
        do_reset();
        pin_hi = 4'b1111;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte({4'b0101, CFG_LO, 1'b0}, a);
        bus_stop();
        check(a, "R5 latched address acked", a, 1);
        bus_start();
        send_byte({4'b1111, CFG_LO, 1'b0}, a);
        bus_stop();
        check(!a, "R5 later pins ignored", a, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_write_burst();
        t_read_back();
        t_rstart();
        t_wrap();
        t_noinc();
        t_mismatch();
        t_pins();
        t_latch();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule